// File: doc/BRIEF.md
# Time-Step Microsequencing Control Unit

This block is the hardwired sequencer of a small accumulator machine. It keeps a one-hot time-step vector and, for each step, drives the control wires of the datapath: a 3-bit bus-source select, a 3-bit bus-destination select, a memory read strobe, a memory write strobe and a 3-bit ALU operation code. The register bank, memory and ALU live outside the block. Their register numbers are fixed: 1 address register, 2 program counter, 3 buffer register, 4 accumulator, 5 input port, 6 output port, 7 instruction register, and 0 for none.

Every instruction begins with the same three fetch steps. The upper four bits of the instruction register come back on `opcode_in`, and bits 11:10 come back on `skip_sel`. The block uses them to pick the execute steps. After the last execute step it returns to step 0. The control word is registered. It is computed one step ahead, so the word and the step vector always belong to the same step. A halt instruction freezes the sequencer until reset.

Top module: `cu_timestep_ctrl`

## Requirements
- R1: While reset is high and in the cycle after it falls, `tstep` is 1 (step 0), `halted` is 0, `rd_sel`=2, `wr_sel`=1, and both strobes and `alu_op` are 0.
- R2: `tstep` always has exactly one bit set. It moves up one bit each cycle and returns to bit 0 after the last step of the instruction.
- R3: Step 0 drives rd=2 and wr=1. Step 1 drives `mem_rd`=1, wr=7 and rd=0. Step 2 drives only `alu_op`=100.
- R4: The opcode is taken from `opcode_in` during step 2 and the steps after it. Its value during steps 0 and 1 has no effect. Opcodes B to F run no execute steps: step 2 is followed by step 0.
- R5: Opcodes 1 (load), 3 (add) and 4 (subtract) share their first two execute steps. Step 3 drives rd=7, wr=1. Step 4 drives `mem_rd`=1, wr=3. Step 5 then differs: load drives rd=3, wr=4; add drives `alu_op`=010; subtract drives `alu_op`=001.
- R6: Opcode 2 (store) runs three execute steps. Step 3 drives rd=7, wr=1. Step 4 drives rd=4, wr=3. Step 5 drives rd=3 with `mem_wr`=1.
- R7: Opcode 0 (jump-and-store) runs five execute steps. Step 3 drives rd=2, wr=3. Step 4 drives rd=7, wr=1. Step 5 drives rd=3 with `mem_wr`. Step 6 drives rd=7, wr=2. Step 7 drives `alu_op`=100.
- R8: Opcode 8 (conditional skip) runs one execute step. Its `alu_op` is 101, 110 or 111 for `skip_sel` 00, 01 or 10, and 000 for `skip_sel` 11.
- R9: Each of these opcodes runs one execute step:
  - 5 (input): rd=5, wr=4.
  - 6 (output): rd=4, wr=6.
  - 9 (jump): rd=7, wr=2.
  - A (clear): `alu_op`=011.
- R10: Opcode 7 (halt) enters step 3 with every control wire at 0 and `halted` at 1. From then until reset, `tstep` and all control outputs hold, whatever `opcode_in` and `skip_sel` do.
- R11: `mem_rd` and `mem_wr` are never both 1. A memory read always has rd=0 and wr equal to 3 or 7. A memory write always has rd=3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode_in | input | 4 | Upper four bits of the instruction register |
| skip_sel | input | 2 | Instruction register bits 11:10, the skip condition |
| rd_sel | output | 3 | Register number driving the data bus (0 = none) |
| wr_sel | output | 3 | Register number loaded from the data bus (0 = none) |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| alu_op | output | 3 | ALU operation code |
| tstep | output | NSTEP | One-hot time-step vector |
| halted | output | 1 | Sticky halt flag |

## Verification
A directed sweep runs all sixteen opcodes, and the skip opcode under all four condition codes. This shows that each opcode has its own length and its own per-step control word, and that an undefined code really ends after fetch. A long random stream of back-to-back instructions follows, with random junk on the opcode inputs during steps 0 and 1. Any early sampling of the opcode, or any length error that shifts later instructions, shows up as a wrong word or step. A final halt with the opcode inputs changing afterwards, followed by a reset, separates a true freeze from a counter that only looks stuck.

// File: rtl/cu_pkg.sv
package cu_pkg;

  // register numbers on the select buses
  localparam logic [2:0] RG_NONE = 3'd0;
  localparam logic [2:0] RG_MAR  = 3'd1;
  localparam logic [2:0] RG_PC   = 3'd2;
  localparam logic [2:0] RG_MBR  = 3'd3;
  localparam logic [2:0] RG_AC   = 3'd4;
  localparam logic [2:0] RG_IN   = 3'd5;
  localparam logic [2:0] RG_OUT  = 3'd6;
  localparam logic [2:0] RG_IR   = 3'd7;

  // ALU operation codes
  localparam logic [2:0] ALU_NOP = 3'b000;
  localparam logic [2:0] ALU_SUB = 3'b001;
  localparam logic [2:0] ALU_ADD = 3'b010;
  localparam logic [2:0] ALU_CLR = 3'b011;
  localparam logic [2:0] ALU_INC = 3'b100;

  // instruction opcodes
  localparam logic [3:0] OP_JNS   = 4'h0;
  localparam logic [3:0] OP_LOAD  = 4'h1;
  localparam logic [3:0] OP_STORE = 4'h2;
  localparam logic [3:0] OP_ADD   = 4'h3;
  localparam logic [3:0] OP_SUB   = 4'h4;
  localparam logic [3:0] OP_IN    = 4'h5;
  localparam logic [3:0] OP_OUT   = 4'h6;
  localparam logic [3:0] OP_HALT  = 4'h7;
  localparam logic [3:0] OP_SKIP  = 4'h8;
  localparam logic [3:0] OP_JUMP  = 4'h9;
  localparam logic [3:0] OP_CLR   = 4'hA;

  // steps 0..FETCH_STEPS-1 are the fetch phase
  localparam int FETCH_STEPS = 3;

  typedef struct packed {
    logic [2:0] rd;
    logic [2:0] wr;
    logic       mr;
    logic       mw;
    logic [2:0] alu;
  } ctrl_t;

  localparam ctrl_t CTRL_IDLE  = '{rd: RG_NONE, wr: RG_NONE, mr: 1'b0, mw: 1'b0, alu: ALU_NOP};
  localparam ctrl_t CTRL_RESET = '{rd: RG_PC,   wr: RG_MAR,  mr: 1'b0, mw: 1'b0, alu: ALU_NOP};

  // number of execute steps after fetch
  function automatic logic [3:0] exec_len(input logic [3:0] op);
    case (op)
      OP_JNS:                              exec_len = 4'd5;
      OP_LOAD, OP_STORE, OP_ADD, OP_SUB:   exec_len = 4'd3;
      OP_IN, OP_OUT, OP_HALT, OP_SKIP,
      OP_JUMP, OP_CLR:                     exec_len = 4'd1;
      default:                             exec_len = 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/cu_step_ctr.sv
module cu_step_ctr
  import cu_pkg::*;
#(
  parameter int NSTEP  = 8,
  parameter int STEP_W = $clog2(NSTEP)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        op,
  output logic [NSTEP-1:0]  tstep,
  output logic              halted,
  output logic [STEP_W-1:0] nxt_idx
);

  logic [NSTEP-1:0]  step_q;
  logic              halt_q;
  logic [STEP_W-1:0] cur_idx;
  logic              last;
  logic              halt_go;

  // one-hot to index
  always_comb begin
    cur_idx = '0;
    for (int i = 0; i < NSTEP; i++)
      if (step_q[i]) cur_idx = STEP_W'(i);
  end

  assign last    = (int'(cur_idx) == FETCH_STEPS - 1 + int'(exec_len(op)));
  assign halt_go = (int'(cur_idx) == FETCH_STEPS - 1) && (op == OP_HALT);

  always_ff @(posedge clk) begin
    if (rst) begin
      step_q <= NSTEP'(1);
      halt_q <= 1'b0;
    end else if (!halt_q) begin
      step_q <= last ? NSTEP'(1) : (step_q << 1);
      if (halt_go) halt_q <= 1'b1;
    end
  end

  always_comb begin
    if (halt_q)    nxt_idx = cur_idx;
    else if (last) nxt_idx = '0;
    else           nxt_idx = cur_idx + STEP_W'(1);
  end

  assign tstep  = step_q;
  assign halted = halt_q;

  assert_onehot_step_R2: assert property (@(posedge clk) disable iff (rst)
    $countones(step_q) == 1);

  assert_fetch_t0_t1_R3: assert property (@(posedge clk) disable iff (rst)
    step_q[0] |=> step_q[1]);

  assert_fetch_t1_t2_R3: assert property (@(posedge clk) disable iff (rst)
    step_q[1] |=> step_q[2]);

  assert_undef_returns_R4: assert property (@(posedge clk) disable iff (rst)
    (step_q[2] && op >= 4'hB) |=> step_q[0]);

  assert_halt_freeze_R10: assert property (@(posedge clk) disable iff (rst)
    halt_q |=> (halt_q && $stable(step_q)));

endmodule

// File: rtl/cu_ucode.sv
module cu_ucode
  import cu_pkg::*;
#(
  parameter int STEP_W = 3
) (
  input  logic [STEP_W-1:0] idx,
  input  logic [3:0]        op,
  input  logic [1:0]        skip_sel,
  output ctrl_t             word
);

  logic [STEP_W-1:0] ex;
  assign ex = idx - STEP_W'(FETCH_STEPS);

  always_comb begin
    word = CTRL_IDLE;
    if (idx == STEP_W'(0)) begin
      word.rd = RG_PC;  word.wr = RG_MAR;
    end else if (idx == STEP_W'(1)) begin
      word.mr = 1'b1;   word.wr = RG_IR;
    end else if (idx == STEP_W'(2)) begin
      word.alu = ALU_INC;
    end else begin
      case (op)
        OP_JNS: begin
          case (ex)
            STEP_W'(0): begin word.rd = RG_PC;  word.wr = RG_MBR; end
            STEP_W'(1): begin word.rd = RG_IR;  word.wr = RG_MAR; end
            STEP_W'(2): begin word.rd = RG_MBR; word.mw = 1'b1;   end
            STEP_W'(3): begin word.rd = RG_IR;  word.wr = RG_PC;  end
            STEP_W'(4): word.alu = ALU_INC;
            default: ;
          endcase
        end
        OP_LOAD, OP_ADD, OP_SUB: begin
          case (ex)
            STEP_W'(0): begin word.rd = RG_IR; word.wr = RG_MAR; end
            STEP_W'(1): begin word.mr = 1'b1;  word.wr = RG_MBR; end
            STEP_W'(2): begin
              if (op == OP_LOAD) begin
                word.rd = RG_MBR; word.wr = RG_AC;
              end else begin
                word.alu = (op == OP_ADD) ? ALU_ADD : ALU_SUB;
              end
            end
            default: ;
          endcase
        end
        OP_STORE: begin
          case (ex)
            STEP_W'(0): begin word.rd = RG_IR;  word.wr = RG_MAR; end
            STEP_W'(1): begin word.rd = RG_AC;  word.wr = RG_MBR; end
            STEP_W'(2): begin word.rd = RG_MBR; word.mw = 1'b1;   end
            default: ;
          endcase
        end
        OP_IN:   if (ex == STEP_W'(0)) begin word.rd = RG_IN; word.wr = RG_AC;  end
        OP_OUT:  if (ex == STEP_W'(0)) begin word.rd = RG_AC; word.wr = RG_OUT; end
        OP_JUMP: if (ex == STEP_W'(0)) begin word.rd = RG_IR; word.wr = RG_PC;  end
        OP_CLR:  if (ex == STEP_W'(0)) word.alu = ALU_CLR;
        OP_SKIP: if (ex == STEP_W'(0))
                   word.alu = (skip_sel == 2'b11) ? ALU_NOP : {1'b1, skip_sel + 2'd1};
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/cu_timestep_ctrl.sv
module cu_timestep_ctrl
  import cu_pkg::*;
#(
  parameter int NSTEP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [3:0]       opcode_in,
  input  logic [1:0]       skip_sel,
  output logic [2:0]       rd_sel,
  output logic [2:0]       wr_sel,
  output logic             mem_rd,
  output logic             mem_wr,
  output logic [2:0]       alu_op,
  output logic [NSTEP-1:0] tstep,
  output logic             halted
);

  localparam int STEP_W = $clog2(NSTEP);

  logic [STEP_W-1:0] nxt_idx;
  ctrl_t             nword;
  ctrl_t             ctrl_q;

  cu_step_ctr #(.NSTEP(NSTEP), .STEP_W(STEP_W)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .op      (opcode_in),
    .tstep   (tstep),
    .halted  (halted),
    .nxt_idx (nxt_idx)
  );

  cu_ucode #(.STEP_W(STEP_W)) u_ucode (
    .idx      (nxt_idx),
    .op       (opcode_in),
    .skip_sel (skip_sel),
    .word     (nword)
  );

  // word for the step being entered, registered alongside the step vector
  always_ff @(posedge clk) begin
    if (rst)          ctrl_q <= CTRL_RESET;
    else if (!halted) ctrl_q <= nword;
  end

  assign rd_sel = ctrl_q.rd;
  assign wr_sel = ctrl_q.wr;
  assign mem_rd = ctrl_q.mr;
  assign mem_wr = ctrl_q.mw;
  assign alu_op = ctrl_q.alu;

  assert_strobe_excl_R11: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  assert_read_target_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (rd_sel == RG_NONE && (wr_sel == RG_MBR || wr_sel == RG_IR)));

  assert_write_source_R11: assert property (@(posedge clk) disable iff (rst)
    mem_wr |-> (rd_sel == RG_MBR));

  assert_fetch_word_R3: assert property (@(posedge clk) disable iff (rst)
    tstep[2] |-> (alu_op == ALU_INC && rd_sel == RG_NONE && wr_sel == RG_NONE));

  assert_halt_word_hold_R10: assert property (@(posedge clk) disable iff (rst)
    halted |=> $stable({rd_sel, wr_sel, mem_rd, mem_wr, alu_op}));

endmodule

// File: tb/tb_cu_timestep_ctrl.sv
module tb_cu_timestep_ctrl;

  localparam int NSTEP = 8;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [3:0]       opcode_in = 4'h0;
  logic [1:0]       skip_sel = 2'b00;
  logic [2:0]       rd_sel, wr_sel, alu_op;
  logic             mem_rd, mem_wr, halted;
  logic [NSTEP-1:0] tstep;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;  // 125 MHz

  cu_timestep_ctrl #(.NSTEP(NSTEP)) dut (
    .clk(clk), .rst(rst), .opcode_in(opcode_in), .skip_sel(skip_sel),
    .rd_sel(rd_sel), .wr_sel(wr_sel), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .alu_op(alu_op), .tstep(tstep), .halted(halted)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [10:0] w(input int rd, input int wr, input int mr,
                                    input int mw, input int alu);
    return {3'(rd), 3'(wr), 1'(mr), 1'(mw), 3'(alu)};
  endfunction

  function automatic int exp_len(input int op);
    case (op)
      0: return 5;
      1, 2, 3, 4: return 3;
      5, 6, 7, 8, 9, 10: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic logic [10:0] exp_word(input int op, input int c, input int k);
    if (k == 0) return w(2, 1, 0, 0, 0);
    if (k == 1) return w(0, 7, 1, 0, 0);
    if (k == 2) return w(0, 0, 0, 0, 4);
    case (op)
      0: case (k)
           3: return w(2, 3, 0, 0, 0);
           4: return w(7, 1, 0, 0, 0);
           5: return w(3, 0, 0, 1, 0);
           6: return w(7, 2, 0, 0, 0);
           default: return w(0, 0, 0, 0, 4);
         endcase
      1, 3, 4: case (k)
           3: return w(7, 1, 0, 0, 0);
           4: return w(0, 3, 1, 0, 0);
           default: return (op == 1) ? w(3, 4, 0, 0, 0) :
                           (op == 3) ? w(0, 0, 0, 0, 2) : w(0, 0, 0, 0, 1);
         endcase
      2: case (k)
           3: return w(7, 1, 0, 0, 0);
           4: return w(4, 3, 0, 0, 0);
           default: return w(3, 0, 0, 1, 0);
         endcase
      5: return w(5, 4, 0, 0, 0);
      6: return w(4, 6, 0, 0, 0);
      8: return w(0, 0, 0, 0, (c == 3) ? 0 : 5 + c);
      9: return w(7, 2, 0, 0, 0);
      10: return w(0, 0, 0, 0, 3);
      default: return w(0, 0, 0, 0, 0);
    endcase
  endfunction

  function automatic string req_of(input int op, input int k);
    if (k < 3) return (op >= 11) ? "R4/R3" : "R3";
    case (op)
      0: return "R7";
      1, 3, 4: return "R5";
      2: return "R6";
      8: return "R8";
      default: return "R9";
    endcase
  endfunction

  function automatic logic [10:0] act_word();
    return {rd_sel, wr_sel, mem_rd, mem_wr, alu_op};
  endfunction

  task automatic check_r11();
    chk(!(mem_rd && mem_wr), "R11", "strobes", {mem_rd, mem_wr}, 0);
    if (mem_rd) chk(rd_sel == 0 && (wr_sel == 3 || wr_sel == 7), "R11", "read sel",
                    {rd_sel, wr_sel}, 0);
    if (mem_wr) chk(rd_sel == 3, "R11", "write src", rd_sel, 3);
  endtask

  // called at a falling edge while the unit sits in step 0
  task automatic run_instr(input int op, input int c);
    int n = 3 + exp_len(op);
    for (int k = 0; k < n; k++) begin
      chk(tstep == (NSTEP'(1) << k), "R2", "tstep", tstep, NSTEP'(1) << k);
      chk(act_word() == exp_word(op, c, k), req_of(op, k), "word",
          act_word(), exp_word(op, c, k));
      check_r11();
      if (k == 0) begin  // junk while opcode must be ignored (R4)
        opcode_in = 4'($urandom_range(15, 0));
        skip_sel  = 2'($urandom_range(3, 0));
      end else if (k == 1) begin
        opcode_in = 4'(op);
        skip_sel  = 2'(c);
      end
      @(negedge clk);
    end
  endtask

  task automatic check_reset_state();
    chk(tstep == NSTEP'(1), "R1", "tstep", tstep, 1);
    chk(halted == 1'b0, "R1", "halted", halted, 0);
    chk(act_word() == w(2, 1, 0, 0, 0), "R1", "word", act_word(), w(2, 1, 0, 0, 0));
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    check_reset_state();

    // directed sweep of every opcode but halt
    for (int op = 0; op < 16; op++)
      if (op != 7) run_instr(op, 0);
    for (int c = 0; c < 4; c++) run_instr(8, c);

    // random back-to-back stream
    for (int i = 0; i < 300; i++) begin
      int op = $urandom_range(15, 0);
      if (op == 7) op = 9;
      run_instr(op, $urandom_range(3, 0));
    end

    // halt: fetch then freeze (R10)
    for (int k = 0; k < 3; k++) begin
      chk(act_word() == exp_word(7, 0, k), "R3", "halt fetch", act_word(), exp_word(7, 0, k));
      if (k == 1) opcode_in = 4'h7;
      @(negedge clk);
    end
    for (int j = 0; j < 8; j++) begin
      chk(tstep == NSTEP'(8), "R10", "frozen tstep", tstep, 8);
      chk(halted == 1'b1, "R10", "halted", halted, 1);
      chk(act_word() == 0, "R10", "frozen word", act_word(), 0);
      opcode_in = 4'($urandom_range(15, 0));
      skip_sel  = 2'($urandom_range(3, 0));
      @(negedge clk);
    end

    rst = 1'b1;
    @(negedge clk);
    check_reset_state();
    rst = 1'b0;
    check_reset_state();
    run_instr(2, 0);
    run_instr(0, 0);

    finish_run();
  end

endmodule